// File: doc/BRIEF.md
# Continuous ADC Sequencer with Threshold-Gated Interrupt

This block drives an external analog-to-digital converter. While its run bit is set it keeps the converter busy: it pulses a start line with the chosen channel, waits for the converter's done strobe and stores the sample in a result register. Then it starts the next conversion at once. Every accepted sample produces an end-of-conversion interrupt pulse. A compare unit can suppress that pulse: it checks the upper eight bits of the stored sample against a programmable threshold, in either a greater-or-equal sense or a strictly-below sense, so that software is woken only when a monitored supply crosses a level.

Configuration arrives through a small write port with four registers. A write to any of them while a conversion is in flight cancels that conversion, and a fresh one starts with the new settings. Clearing the run bit cancels the conversion and stops the sequence.

Top module: `adc_seq_ctrl`

## Requirements
- R1: Register map (2-bit address): 0 = mode, where bit 0 is the run bit; 1 = channel, where bits [CH_W-1:0] are the channel; 2 = 8-bit threshold; 3 = compare control, where bit 0 is the gate enable and bit 1 selects the below sense. When the run bit goes from 0 to 1 while idle, `conv_start` pulses for one cycle in the second cycle after the write cycle, and `conv_chan` carries the channel register's value.
- R2: A `conv_done` accepted during a conversion loads `conv_data` into `result`, which is visible in the cycle after the done. If the run bit is still set, `conv_start` pulses in that same cycle, so conversions run back to back.
- R3: A write to any of the four registers while a conversion is in flight aborts it. `conv_start` is low in the cycle after the write cycle and pulses in the cycle after that, using the newly written settings.
- R4: Clearing the run bit during a conversion aborts it. No further `conv_start` follows, and a late `conv_done` leaves `result` and `irq` unchanged.
- R5: With the gate enable at 0, `irq` pulses for every accepted conversion.
- R6: With the gate enable at 1 and the below sense at 0, `irq` pulses only when `result[9:2]` is greater than or equal to the threshold.
- R7: With the gate enable at 1 and the below sense at 1, `irq` pulses only when `result[9:2]` is strictly less than the threshold.
- R8: `result` is overwritten by every accepted conversion, whether or not `irq` fires.
- R9: `irq` is a one-cycle pulse in the cycle after `result` updates, and it is decided from the newly stored value.
- R10: A `conv_done` in the same cycle as a register write is discarded: `result` does not change and no `irq` follows.
- R11: During reset, `conv_start`, `irq`, `result` and `conv_chan` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register select |
| cfg_wdata | input | WD_W (8) | Write data |
| conv_done | input | 1 | Converter finished; sample valid this cycle |
| conv_data | input | RES_W (10) | Raw sample from the converter |
| conv_start | output | 1 | One-cycle conversion request |
| conv_chan | output | CH_W (3) | Channel latched at the last start |
| result | output | RES_W (10) | Last accepted conversion result |
| irq | output | 1 | Conversion-end interrupt pulse |

## Verification
The bench aims at the exact threshold boundary, where upper byte equals threshold: a design that uses > instead of >=, or <= instead of <, gives the wrong interrupt there. It places a done strobe in the same cycle as a register write, where a design that gives the done priority would store a stale sample. It changes the channel halfway through a conversion, where a design that does not restart would return the old channel's sample. A late done after the run bit is cleared catches a sequencer that still accepts samples while idle. The interrupt is checked cycle by cycle, so a compare against the previous result or a pulse longer than one cycle shows up.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    typedef enum logic [1:0] {
        CFG_MODE   = 2'd0,
        CFG_CHAN   = 2'd1,
        CFG_THRESH = 2'd2,
        CFG_CMP    = 2'd3
    } cfg_sel_e;

    localparam int MODE_RUN_BIT  = 0;
    localparam int CMP_GATE_BIT  = 0;
    localparam int CMP_BELOW_BIT = 1;

    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_BUSY = 1'b1
    } seq_state_e;

endpackage

// File: rtl/adc_cfg_regs.sv
module adc_cfg_regs
    import adc_seq_pkg::*;
#(
    parameter int CH_W  = 3,
    parameter int THR_W = 8,
    parameter int WD_W  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [1:0]       addr,
    input  logic [WD_W-1:0]  wdata,
    output logic             run,
    output logic [CH_W-1:0]  chan,
    output logic [THR_W-1:0] thresh,
    output logic             gate_en,
    output logic             below
);

    typedef struct packed {
        logic             run;
        logic [CH_W-1:0]  chan;
        logic [THR_W-1:0] thresh;
        logic             gate_en;
        logic             below;
    } cfg_t;

    cfg_t cfg_d, cfg_q;
    logic unused_wdata;

    assign unused_wdata = ^wdata;

    always_comb begin
        cfg_d = cfg_q;
        if (we) begin
            case (cfg_sel_e'(addr))
                CFG_MODE:   cfg_d.run     = wdata[MODE_RUN_BIT];
                CFG_CHAN:   cfg_d.chan    = wdata[CH_W-1:0];
                CFG_THRESH: cfg_d.thresh  = wdata[THR_W-1:0];
                CFG_CMP: begin
                    cfg_d.gate_en = wdata[CMP_GATE_BIT];
                    cfg_d.below   = wdata[CMP_BELOW_BIT];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign run     = cfg_q.run;
    assign chan    = cfg_q.chan;
    assign thresh  = cfg_q.thresh;
    assign gate_en = cfg_q.gate_en;
    assign below   = cfg_q.below;

    // R3
    chan_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == 2'd1) |=> chan == $past(wdata[CH_W-1:0]));

    // R1
    run_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == 2'd0) |=> run == $past(wdata[MODE_RUN_BIT]));

endmodule

// File: rtl/adc_irq_gate.sv
module adc_irq_gate #(
    parameter int RES_W = 10,
    parameter int THR_W = 8
) (
    input  logic [RES_W-1:0] result,
    input  logic [THR_W-1:0] thresh,
    input  logic             gate_en,
    input  logic             below,
    output logic             fire
);

    logic [THR_W-1:0] upper;
    logic             at_or_above;

    assign upper = result[RES_W-1 -: THR_W];

    generate
        if (RES_W > THR_W) begin : g_low_bits
            logic unused_low;
            assign unused_low = ^result[RES_W-THR_W-1:0];
        end
    endgenerate

    always_comb begin
        at_or_above = (upper >= thresh);
        if (!gate_en)   fire = 1'b1;
        else if (below) fire = !at_or_above;
        else            fire = at_or_above;
    end

endmodule

// File: rtl/adc_conv_seq.sv
module adc_conv_seq
    import adc_seq_pkg::*;
#(
    parameter int RES_W = 10,
    parameter int CH_W  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic             run,
    input  logic [CH_W-1:0]  chan,
    input  logic             conv_done,
    input  logic [RES_W-1:0] conv_data,
    input  logic             fire,
    output logic             start,
    output logic [CH_W-1:0]  chan_out,
    output logic [RES_W-1:0] result,
    output logic             irq
);

    typedef struct packed {
        seq_state_e       state;
        logic             start;
        logic [CH_W-1:0]  chan;
        logic [RES_W-1:0] result;
        logic             pend;
        logic             irq;
    } seq_t;

    seq_t s_d, s_q;
    logic accept;

    always_comb begin
        s_d       = s_q;
        s_d.start = 1'b0;
        s_d.pend  = 1'b0;
        s_d.irq   = s_q.pend & fire;
        accept    = conv_done && (s_q.state == SEQ_BUSY) && !cfg_we;

        if (cfg_we) begin
            s_d.state = SEQ_IDLE;
        end else if (accept) begin
            s_d.result = conv_data;
            s_d.pend   = 1'b1;
            if (run) begin
                s_d.start = 1'b1;
                s_d.chan  = chan;
            end else begin
                s_d.state = SEQ_IDLE;
            end
        end else if (s_q.state == SEQ_IDLE && run) begin
            s_d.start = 1'b1;
            s_d.chan  = chan;
            s_d.state = SEQ_BUSY;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign start    = s_q.start;
    assign chan_out = s_q.chan;
    assign result   = s_q.result;
    assign irq      = s_q.irq;

    // R1
    start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.start |-> s_q.state == SEQ_BUSY);

    // R2
    result_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_done && s_q.state == SEQ_BUSY && !cfg_we) |=> s_q.result == $past(conv_data));

    // R3
    abort_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> (!s_q.start && s_q.state == SEQ_IDLE));

    // R4
    halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && s_q.state == SEQ_IDLE && !cfg_we) |=> !s_q.start);

    // R9
    irq_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.irq |-> $past(s_q.pend));

    // R10
    discard_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_done && cfg_we) |=> $stable(s_q.result));

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int CH_W  = 3,
    parameter int RES_W = 10,
    parameter int THR_W = 8,
    parameter int WD_W  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [1:0]       cfg_addr,
    input  logic [WD_W-1:0]  cfg_wdata,
    input  logic             conv_done,
    input  logic [RES_W-1:0] conv_data,
    output logic             conv_start,
    output logic [CH_W-1:0]  conv_chan,
    output logic [RES_W-1:0] result,
    output logic             irq
);

    logic             run;
    logic [CH_W-1:0]  chan;
    logic [THR_W-1:0] thresh;
    logic             gate_en;
    logic             below;
    logic             fire;

    adc_cfg_regs #(.CH_W(CH_W), .THR_W(THR_W), .WD_W(WD_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (cfg_we),
        .addr    (cfg_addr),
        .wdata   (cfg_wdata),
        .run     (run),
        .chan    (chan),
        .thresh  (thresh),
        .gate_en (gate_en),
        .below   (below)
    );

    adc_conv_seq #(.RES_W(RES_W), .CH_W(CH_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .run       (run),
        .chan      (chan),
        .conv_done (conv_done),
        .conv_data (conv_data),
        .fire      (fire),
        .start     (conv_start),
        .chan_out  (conv_chan),
        .result    (result),
        .irq       (irq)
    );

    adc_irq_gate #(.RES_W(RES_W), .THR_W(THR_W)) u_gate (
        .result  (result),
        .thresh  (thresh),
        .gate_en (gate_en),
        .below   (below),
        .fire    (fire)
    );

endmodule

// File: tb/adc_seq_ctrl_bench.sv
`timescale 1ns/1ps
module adc_seq_ctrl_bench;

    localparam int CH_W  = 3;
    localparam int RES_W = 10;
    localparam int THR_W = 8;
    localparam int WD_W  = 8;
    localparam int LAT   = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cfg_we = 1'b0;
    logic [1:0]       cfg_addr = '0;
    logic [WD_W-1:0]  cfg_wdata = '0;
    logic             conv_done;
    logic [RES_W-1:0] conv_data;
    logic             conv_start;
    logic [CH_W-1:0]  conv_chan;
    logic [RES_W-1:0] result;
    logic             irq;

    always #2.5 clk = ~clk;

    adc_seq_ctrl #(.CH_W(CH_W), .RES_W(RES_W), .THR_W(THR_W), .WD_W(WD_W)) u_adc_seq_ctrl (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .conv_done(conv_done), .conv_data(conv_data), .conv_start(conv_start),
        .conv_chan(conv_chan), .result(result), .irq(irq)
    );

    // converter model and scoreboard queue
    logic [RES_W-1:0] samp [0:7];
    logic [RES_W-1:0] exp_q [$];
    int               m_cnt;
    logic [CH_W-1:0]  m_chan;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_cnt     <= 0;
            m_chan    <= '0;
            conv_done <= 1'b0;
            conv_data <= '0;
        end else begin
            conv_done <= 1'b0;
            if (conv_start) begin
                m_cnt  <= LAT;
                m_chan <= conv_chan;
            end else if (m_cnt != 0) begin
                m_cnt <= m_cnt - 1;
                if (m_cnt == 1) begin
                    conv_done <= 1'b1;
                    conv_data <= samp[m_chan];
                    exp_q.push_back(samp[m_chan]);
                end
            end
        end
    end

    int  n_chk = 0;
    int  n_fail = 0;
    int  mon_done = 0;
    bit  ignore_done = 1'b0;
    bit  sh_run = 1'b0, sh_gate = 1'b0, sh_below = 1'b0;
    logic [7:0] sh_thr = '0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic bit exp_irq(input logic [RES_W-1:0] d);
        logic [7:0] up;
        up = d[9:2];
        if (!sh_gate) return 1'b1;
        return sh_below ? (up < sh_thr) : (up >= sh_thr);
    endfunction

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        case (a)
            2'd0: sh_run = d[0];
            2'd2: sh_thr = d;
            2'd3: begin sh_gate = d[0]; sh_below = d[1]; end
            default: ;
        endcase
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic wait_conv(input int n);
        repeat (n) begin
            int c;
            c = mon_done;
            wait (mon_done > c);
        end
    endtask

    // monitor: pops expected samples and checks result/irq timing
    initial begin
        forever begin
            @(negedge clk); #1;
            if (rst_n && conv_done) begin
                logic [RES_W-1:0] d, prev;
                bit drop, e;
                string tag;
                d    = exp_q.pop_front();
                drop = cfg_we || ignore_done;
                tag  = cfg_we ? "R10" : "R4";
                prev = result;
                if (drop) begin
                    repeat (3) begin
                        @(negedge clk); #1;
                        chk(result == prev, tag, int'(result), int'(prev));
                        chk(irq == 1'b0, tag, int'(irq), 0);
                    end
                end else begin
                    @(negedge clk); #1;
                    e = exp_irq(d);
                    chk(result == d, (sh_gate && !e) ? "R8" : "R2", int'(result), int'(d));
                    chk(irq == 1'b0, "R9", int'(irq), 0);
                    chk(conv_start == sh_run, "R2", int'(conv_start), int'(sh_run));
                    @(negedge clk); #1;
                    chk(irq == e, !sh_gate ? "R5" : (sh_below ? "R7" : "R6"), int'(irq), int'(e));
                    @(negedge clk); #1;
                    chk(irq == 1'b0, "R9", int'(irq), 0);
                end
                mon_done++;
            end
        end
    end

    task automatic summary;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        for (int i = 0; i < 8; i++) samp[i] = 10'(i * 37 + 5);
        repeat (4) @(negedge clk);
        #1;
        // R11
        chk(conv_start == 1'b0, "R11", int'(conv_start), 0);
        chk(irq == 1'b0, "R11", int'(irq), 0);
        chk(result == '0, "R11", int'(result), 0);
        chk(conv_chan == '0, "R11", int'(conv_chan), 0);
        @(negedge clk);
        rst_n = 1'b1;

        samp[0] = 10'h200;
        wr(2'd2, 8'h80);
        wr(2'd3, 8'h00);
        wr(2'd1, 8'h00);
        wr(2'd0, 8'h01);
        #1;
        // R1: start arrives in the second cycle after the write
        chk(conv_start == 1'b0, "R1", int'(conv_start), 0);
        @(negedge clk); #1;
        chk(conv_start == 1'b1, "R1", int'(conv_start), 1);
        chk(conv_chan == 3'd0, "R1", int'(conv_chan), 0);
        wait_conv(2);                       // R5 ungated, back-to-back R2

        wr(2'd3, 8'h01);                    // gate, at-or-above sense (R6)
        samp[0] = 10'h1FC;                  // upper 0x7F: no irq, result still stored (R8)
        wait_conv(2);
        samp[0] = 10'h203;                  // upper 0x80 == threshold: irq (R6)
        wait_conv(2);

        wr(2'd3, 8'h03);                    // below sense (R7)
        samp[0] = 10'h1FF;
        wait_conv(2);
        samp[0] = 10'h200;
        wait_conv(2);

        // R3: switch channel mid-conversion
        wait (m_cnt == 8);
        samp[1] = 10'h155;
        wr(2'd1, 8'h01);
        #1;
        chk(conv_start == 1'b0, "R3", int'(conv_start), 0);
        @(negedge clk); #1;
        chk(conv_start == 1'b1, "R3", int'(conv_start), 1);
        chk(conv_chan == 3'd1, "R3", int'(conv_chan), 1);
        wait_conv(1);
        chk(result == 10'h155, "R3", int'(result), 'h155);

        // R10: write lands in the same cycle as done
        do @(negedge clk); while (!conv_done);
        cfg_we = 1'b1; cfg_addr = 2'd2; cfg_wdata = 8'h80;
        @(negedge clk);
        cfg_we = 1'b0;
        wait_conv(2);

        // R4: clear run mid-conversion, late done must be ignored
        wait (m_cnt == 8);
        ignore_done = 1'b1;
        begin
            logic [RES_W-1:0] held;
            bit bad;
            held = result;
            bad  = 1'b0;
            wr(2'd0, 8'h00);
            repeat (40) begin
                @(negedge clk); #1;
                if (conv_start || irq || result != held) bad = 1'b1;
            end
            chk(!bad, "R4", int'(bad), 0);
        end
        ignore_done = 1'b0;

        summary();
        $finish;
    end

endmodule